// File: doc/BRIEF.md
# Five-Channel Overflow Timer Bank

The block is a bank of five independent 16-bit up-counters reached over a simple 8-bit register bus. One shared start register turns each channel on or off. Each channel also has a control register that picks how fast it counts, an interrupt-enable register, a status register holding a sticky overflow flag, and a counter that software reads and writes one byte at a time.

A running channel counts the system clock through a prescaler that divides by 1, 2, 4 or 8. When the counter passes 0xFFFF it wraps to zero and sets its overflow flag. If the channel's enable bit is set, the channel then drives a level interrupt request. A priority encoder gives the fixed vector number of the lowest-numbered channel that is requesting. Software clears a request by writing zero to the flag.

Top module: `ovf_timer_bank`

## Requirements
- R1: After reset every register and counter reads 0, every irq bit is low, irq_any is low and irq_vec is 0.
- R2: Bit n of the start register (offset 0x60, n = 0 to 4) runs channel n. While the bit is clear, that channel's counter holds its value.
- R3: Control bits [1:0] (channel control at 0x64, 0x6E, 0x78, 0x82, 0x92) set the divide: 00 = 1, 01 = 2, 10 = 4, 11 = 8. The prescaler restarts when the channel starts and when its counter is written. From the clock edge that sets the start bit, the flag is visible after exactly divide × (65536 − loaded value) edges.
- R4: While control bit 2 is set, the channel does not count, even if its start bit is set.
- R5: The counter high/low bytes are at 0x68/0x69, 0x72/0x73, 0x7C/0x7D, 0x86/0x87 and 0x96/0x97. Writing one byte leaves the other byte unchanged. In that cycle the write takes priority over counting.
- R6: On overflow the counter becomes 0 and keeps counting. Status bit 2 (status at 0x67, 0x71, 0x7B, 0x85, 0x95) is set and stays set until software writes 0 to it. Writing 1 to the bit does not set it. An overflow in the same cycle as a clearing write leaves the flag set. The other status bits read back as written.
- R7: irq[n] is high exactly when channel n's overflow flag is set and bit 2 of its enable register (0x66, 0x70, 0x7A, 0x84, 0x94) is set.
- R8: irq_any is the OR of all irq bits. irq_vec is 26 + 4·n for the lowest-numbered requesting channel n, and 0 when none is requesting.
- R9: A read returns its data on bus_rdata in the cycle after the request, and bus_rdata is 0 otherwise. Other offsets in 0x60–0x9F read back their last written value. Writes outside that window are ignored and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 5 | Per-channel level interrupt request |
| irq_any | output | 1 | Any channel requesting |
| irq_vec | output | 6 | Vector of the lowest requesting channel |

## Verification
Counters are loaded near the top of their range, and the time to overflow is measured at divide 1 and divide 8. This tells a prescaler that miscounts its period from one that is correct. Stopped channels and channels with the external-source bit set are read twice, far apart, which separates "holds" from "counts slowly". A channel with its enable clear is allowed to overflow, which separates the flag from the request. Set-then-clear status writes show that only a zero clears the flag. A long pseudo-random run, biased toward counter high bytes of 0xFF, is compared on every cycle against a behavioural model. It covers simultaneous requests from several channels, and so the vector priority, as well as writes landing on the overflow cycle.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  // Channel register placement inside the window (software decodes these)
  localparam int CH_BASE0     = 'h64;
  localparam int CH_PITCH     = 10;
  localparam int CH_LAST_BASE = 'h92;
  localparam int OFS_CTRL     = 0;
  localparam int OFS_IEN      = 2;
  localparam int OFS_STS      = 3;
  localparam int OFS_CHI      = 4;
  localparam int OFS_CLO      = 5;

  localparam int EXT_BIT  = 2;   // control: external source select
  localparam int FLAG_BIT = 2;   // status: overflow flag
  localparam int IEN_BIT  = 2;   // enable: overflow interrupt

  function automatic int chan_base(input int n);
    return (n < 4) ? CH_BASE0 + CH_PITCH * n : CH_LAST_BASE;
  endfunction
endpackage

// File: rtl/ovf_prescaler.sv
module ovf_prescaler #(
  parameter int PRE_W = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] limit;

  assign limit = (PRE_W'(1) << sel) - PRE_W'(1);
  assign tick  = en & ~clr & (pcnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr || !en) pcnt <= '0;
    else if (tick)         pcnt <= '0;
    else                   pcnt <= pcnt + PRE_W'(1);
  end

  // R3: with a divide above one, two ticks never come back to back
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
    tick && sel != '0 |=> !tick || sel == '0);
endmodule

// File: rtl/ovf_channel.sv
module ovf_channel import ovf_timer_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 3,
  parameter int SEL_W  = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_bit,
  input  logic              wr_ctrl,
  input  logic              wr_ien,
  input  logic              wr_sts,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] ien_q,
  output logic [DATA_W-1:0] sts_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              irq
);
  logic              active, cnt_wr, tick, wrap, flag;
  logic [DATA_W-1:0] sts_keep;

  assign active = start_bit & ~ctrl_q[EXT_BIT];
  assign cnt_wr = wr_hi | wr_lo;

  ovf_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .en(active), .clr(cnt_wr),
    .sel(ctrl_q[SEL_W-1:0]), .tick(tick)
  );

  assign wrap = tick & ~cnt_wr & (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
      if (wr_lo) cnt_q[DATA_W-1:0]     <= wdata;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      ctrl_q   <= '0;
      ien_q    <= '0;
      sts_keep <= '0;
    end else begin
      if (wrap)        flag <= 1'b1;
      else if (wr_sts) flag <= flag & wdata[FLAG_BIT];
      if (wr_sts)  sts_keep <= wdata;
      if (wr_ctrl) ctrl_q   <= wdata;
      if (wr_ien)  ien_q    <= wdata;
    end
  end

  always_comb begin
    sts_q           = sts_keep;
    sts_q[FLAG_BIT] = flag;
  end

  assign irq = flag & ien_q[IEN_BIT];

  // R2: a stopped channel holds its count
  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    !start_bit && !cnt_wr |=> $stable(cnt_q));
  // R4: external-source select freezes the count
  assert_hold_ext_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[EXT_BIT] && !cnt_wr |=> $stable(cnt_q));
  // R5: a high-byte write keeps the low byte
  assert_byte_keep_R5: assert property (@(posedge clk) disable iff (rst)
    wr_hi && !wr_lo |=> cnt_q[DATA_W-1:0] == $past(cnt_q[DATA_W-1:0]));
  // R6: wrap yields zero and a raised flag
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
    tick && !cnt_wr && cnt_q == '1 |=> cnt_q == '0 && flag);
  // R6: flag is sticky without a status write
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    flag && !wr_sts |=> flag);
endmodule

// File: rtl/ovf_timer_bank.sv
module ovf_timer_bank import ovf_timer_pkg::*; #(
  parameter int NCH       = 5,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int PRE_W     = 3,
  parameter int SEL_W     = 2,
  parameter int WIN_LO    = 'h60,
  parameter int WIN_DEPTH = 64,
  parameter int START_OFS = 'h60,
  parameter int VEC_BASE  = 26,
  parameter int VEC_STEP  = 4,
  parameter int VEC_W     = 6,
  localparam int CNT_W    = 2 * DATA_W,
  localparam int IDX_W    = $clog2(WIN_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq,
  output logic              irq_any,
  output logic [VEC_W-1:0]  irq_vec
);
  logic              wr_go, in_win;
  logic [ADDR_W-1:0] win_off;
  logic [IDX_W-1:0]  win_idx;
  logic [DATA_W-1:0] start_q, rd_mux;
  logic [DATA_W-1:0] scratch [WIN_DEPTH];
  logic [DATA_W-1:0] ctrl_v [NCH];
  logic [DATA_W-1:0] ien_v  [NCH];
  logic [DATA_W-1:0] sts_v  [NCH];
  logic [CNT_W-1:0]  cnt_v  [NCH];

  assign wr_go   = bus_sel & bus_wr;
  assign in_win  = (int'(bus_addr) >= WIN_LO) && (int'(bus_addr) < WIN_LO + WIN_DEPTH);
  assign win_off = bus_addr - ADDR_W'(WIN_LO);
  assign win_idx = win_off[IDX_W-1:0];

  // Backing store for the whole window; named registers override it on read
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN_DEPTH; i++) scratch[i] <= '0;
    end else if (wr_go && in_win) begin
      scratch[win_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) start_q <= '0;
    else if (wr_go && bus_addr == ADDR_W'(START_OFS)) start_q <= bus_wdata;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int B = chan_base(g);
    ovf_channel #(.DATA_W(DATA_W), .PRE_W(PRE_W), .SEL_W(SEL_W)) u_ch (
      .clk(clk), .rst(rst), .start_bit(start_q[g]),
      .wr_ctrl(wr_go && bus_addr == ADDR_W'(B + OFS_CTRL)),
      .wr_ien (wr_go && bus_addr == ADDR_W'(B + OFS_IEN)),
      .wr_sts (wr_go && bus_addr == ADDR_W'(B + OFS_STS)),
      .wr_hi  (wr_go && bus_addr == ADDR_W'(B + OFS_CHI)),
      .wr_lo  (wr_go && bus_addr == ADDR_W'(B + OFS_CLO)),
      .wdata(bus_wdata),
      .ctrl_q(ctrl_v[g]), .ien_q(ien_v[g]), .sts_q(sts_v[g]),
      .cnt_q(cnt_v[g]), .irq(irq[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (in_win) rd_mux = scratch[win_idx];
    if (bus_addr == ADDR_W'(START_OFS)) rd_mux = start_q;
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(chan_base(n) + OFS_CTRL)) rd_mux = ctrl_v[n];
      if (bus_addr == ADDR_W'(chan_base(n) + OFS_IEN))  rd_mux = ien_v[n];
      if (bus_addr == ADDR_W'(chan_base(n) + OFS_STS))  rd_mux = sts_v[n];
      if (bus_addr == ADDR_W'(chan_base(n) + OFS_CHI))  rd_mux = cnt_v[n][CNT_W-1:DATA_W];
      if (bus_addr == ADDR_W'(chan_base(n) + OFS_CLO))  rd_mux = cnt_v[n][DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= (bus_sel && !bus_wr) ? rd_mux : '0;
  end

  // Lowest-numbered requester wins
  always_comb begin
    irq_any = |irq;
    irq_vec = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (irq[i]) irq_vec = VEC_W'(VEC_BASE + VEC_STEP * i);
  end

  // R8: a request always carries a vector from the channel range
  assert_vec_range_R8: assert property (@(posedge clk) disable iff (rst)
    irq_any |-> irq_vec >= VEC_W'(VEC_BASE) && irq_vec <= VEC_W'(VEC_BASE + VEC_STEP * (NCH - 1)));
  // R8: no request means vector zero
  assert_vec_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_any |-> irq_vec == '0);
  // R9: bus_rdata is zero the cycle after a non-read
  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> bus_rdata == '0);
endmodule

// File: tb/ovf_timer_bank_test.sv
module ovf_timer_bank_test;
  logic       clk = 0, rst = 1;
  logic       bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [4:0] irq;
  logic       irq_any;
  logic [5:0] irq_vec;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  ovf_timer_bank uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .irq_any(irq_any), .irq_vec(irq_vec)
  );

  // ---------------- behavioural reference ----------------
  int bases[5] = '{'h64, 'h6E, 'h78, 'h82, 'h92};
  int m_start;
  int m_ctrl[5], m_ien[5], m_keep[5], m_flag[5], m_cnt[5], m_pre[5];
  int m_mem[64];
  int exp_rd;

  function automatic int model_read(int a);
    int r = 0;
    if (a >= 'h60 && a < 'hA0) r = m_mem[a - 'h60];
    if (a == 'h60) r = m_start;
    for (int n = 0; n < 5; n++) begin
      if (a == bases[n])     r = m_ctrl[n];
      if (a == bases[n] + 2) r = m_ien[n];
      if (a == bases[n] + 3) r = (m_keep[n] & 'hFB) | (m_flag[n] << 2);
      if (a == bases[n] + 4) r = m_cnt[n] >> 8;
      if (a == bases[n] + 5) r = m_cnt[n] & 'hFF;
    end
    return r;
  endfunction

  function automatic string tag_of(int a);
    for (int n = 0; n < 5; n++) begin
      if (a == bases[n] + 4 || a == bases[n] + 5) return "R5";
      if (a == bases[n] + 3) return "R6";
    end
    return "R9";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_start = 0; exp_rd = 0;
      for (int n = 0; n < 5; n++) begin
        m_ctrl[n] = 0; m_ien[n] = 0; m_keep[n] = 0;
        m_flag[n] = 0; m_cnt[n] = 0; m_pre[n] = 0;
      end
      for (int i = 0; i < 64; i++) m_mem[i] = 0;
    end else begin
      int a, d;
      bit w;
      a = bus_addr; d = bus_wdata; w = bus_sel && bus_wr;
      exp_rd = (bus_sel && !bus_wr) ? model_read(a) : 0;
      for (int n = 0; n < 5; n++) begin
        bit run, cw, ov, tk;
        int div;
        run = ((m_start >> n) & 1) && !(m_ctrl[n] & 4);
        div = 1 << (m_ctrl[n] & 3);
        cw  = w && (a == bases[n] + 4 || a == bases[n] + 5);
        tk  = run && !cw && (m_pre[n] == div - 1);
        ov  = 0;
        if (cw) begin
          if (a == bases[n] + 4) m_cnt[n] = (d << 8) | (m_cnt[n] & 'hFF);
          else                   m_cnt[n] = (m_cnt[n] & 'hFF00) | d;
          m_pre[n] = 0;
        end else if (!run) m_pre[n] = 0;
        else if (tk) begin
          m_pre[n] = 0;
          if (m_cnt[n] == 'hFFFF) begin m_cnt[n] = 0; ov = 1; end
          else m_cnt[n] = m_cnt[n] + 1;
        end else m_pre[n] = (m_pre[n] + 1) & 7;
        if (ov) m_flag[n] = 1;
        else if (w && a == bases[n] + 3) m_flag[n] = m_flag[n] & ((d >> 2) & 1);
        if (w && a == bases[n] + 3) m_keep[n] = d;
        if (w && a == bases[n])     m_ctrl[n] = d;
        if (w && a == bases[n] + 2) m_ien[n] = d;
      end
      if (w && a >= 'h60 && a < 'hA0) m_mem[a - 'h60] = d;
      if (w && a == 'h60) m_start = d;
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      int ei, ev;
      ei = 0; ev = 0;
      for (int n = 4; n >= 0; n--)
        if (m_flag[n] && (m_ien[n] & 4)) begin ei |= (1 << n); ev = 26 + 4 * n; end
      check(tag_of(bus_addr), bus_rdata, exp_rd, "read data vs model");
      check("R7", irq, ei, "irq vs model");
      check("R8", {irq_any, irq_vec}, {ei != 0, 6'(ev)}, "vector vs model");
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 8'(a);
    @(negedge clk);
    bus_sel = 0;
    v = bus_rdata;
  endtask

  task automatic time_to_irq(input int ch, output int k);
    k = 0;
    while (irq[ch] == 0 && k < 1000) begin @(negedge clk); k++; end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int v, v2, k;
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd('h60, v); check("R1", v, 0, "start after reset");
    rd('h64, v); check("R1", v, 0, "ctrl0 after reset");
    rd('h69, v); check("R1", v, 0, "cnt0 low after reset");
    check("R1", {irq_any, irq, irq_vec}, 0, "irq outputs after reset");
    // R9 scratch window and outside writes
    wr('h61, 'hA5); rd('h61, v); check("R9", v, 'hA5, "scratch readback");
    wr('hA0, 'h77); rd('hA0, v); check("R9", v, 0, "outside window read");
    rd('h5F, v); check("R9", v, 0, "below window read");
    // R5 byte-wise counter access
    wr('h72, 'h12); wr('h73, 'h34);
    rd('h72, v); check("R5", v, 'h12, "cnt1 high");
    wr('h72, 'h56); rd('h73, v); check("R5", v, 'h34, "low kept after high write");
    // R3 divide 1: 0xFFF0 -> 16 edges
    wr('h64, 0); wr('h66, 4); wr('h68, 'hFF); wr('h69, 'hF0);
    wr('h60, 1);
    time_to_irq(0, k); check("R3", k, 16, "edges to overflow at divide 1");
    check("R8", irq_vec, 26, "vector of channel 0");
    rd('h67, v); check("R6", v & 4, 4, "flag set on overflow");
    rd('h68, v); check("R6", v, 0, "counter wrapped to zero");
    wr('h67, 0); check("R7", irq[0], 0, "irq drops after flag clear");
    // R3 divide 8: 0xFFFE -> 16 edges
    wr('h82, 3); wr('h84, 4); wr('h86, 'hFF); wr('h87, 'hFE);
    wr('h60, 'h09);
    time_to_irq(3, k); check("R3", k, 16, "edges to overflow at divide 8");
    check("R8", irq_vec, 38, "vector of channel 3");
    // R2 stop holds
    wr('h60, 'h08);
    rd('h69, v); repeat (10) @(negedge clk); rd('h69, v2);
    check("R2", v2, v, "stopped counter holds");
    // R4 external-source bit blocks counting
    wr('h6E, 4); wr('h60, 'h0A);
    repeat (20) @(negedge clk);
    rd('h73, v); check("R4", v, 'h34, "external-source channel frozen");
    // R7 flag without enable gives no request
    wr('h78, 1); wr('h7A, 0); wr('h7C, 'hFF); wr('h7D, 'hFF);
    wr('h60, 'h0E);
    repeat (5) @(negedge clk);
    rd('h7B, v); check("R6", v, 4, "ch2 flag set");
    check("R7", irq[2], 0, "no irq with enable clear");
    // R6 writing one does not set the flag
    wr('h7B, 0); wr('h7B, 4);
    rd('h7B, v); check("R6", v, 0, "write one leaves flag clear");
    // pseudo-random phase compared every cycle
    lf = 32'h1234_5678;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      bus_sel   = (lf[1:0] != 0);
      bus_wr    = lf[2] | lf[3];
      bus_addr  = 8'('h5C + (lf[15:8] % 72));
      bus_wdata = lf[23:16];
      for (int n = 0; n < 5; n++)
        if (bus_addr == 8'(bases[n] + 4) && lf[4]) bus_wdata = 8'hFF;
      if (bus_addr == 8'h60 && lf[5]) bus_wdata = bus_wdata | 8'h1F;
      for (int n = 0; n < 5; n++)
        if (bus_addr == 8'(bases[n]) && lf[6]) bus_wdata = bus_wdata & 8'hF8;
    end
    @(negedge clk);
    bus_sel = 0;
    @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule